// File: doc/BRIEF.md
# Network Packet Latency and Throughput Monitor

This block sits beside a packet network and watches two event streams: header flits leaving their source cores and tail flits accepted at their destinations. Each packet in flight is identified by a tag. When a header is seen, the current cycle number is written into a per-tag timestamp slot. When the matching tail arrives, the difference gives the packet latency. The monitor then accumulates the number of completed packets, the latency sum and the hop-count sum. Software or a test environment later divides these totals to get average latency, throughput and energy per packet. The monitor also counts injected flits across all cores, which gives the offered load.

Statistics are gated by a two-phase schedule that starts when reset is released. A warm-up phase comes first, during which nothing is recorded. A measurement window of fixed length follows. After the window the totals freeze and remain readable through a select-driven readout port. The monitor also records the span from the first header in the window to the last counted tail. That span is the elapsed time used in the throughput formula.

Top module: `noc_perf_monitor`

## Requirements
- R1: While reset is held, every readout selection returns 0 and `meas_active`, `window_done` and `orphan_err` are all 0.
- R2: Cycle 0 is the first clock edge with reset released. `meas_active` is 1 exactly in cycles WARMUP_CYC to WARMUP_CYC+WINDOW_CYC-1. `window_done` is 1 from cycle WARMUP_CYC+WINDOW_CYC onward.
- R3: A packet is counted when its header and its tail both fall inside the window. For each counted packet the message count rises by one and the latency sum rises by the tail cycle minus the header cycle. Tail and header must be at least one cycle apart.
- R4: Injected flits seen during warm-up are never counted. A packet whose header falls in warm-up is excluded even when its tail arrives inside the window.
- R5: For each counted packet, the hop sum rises by the `tail_hops` value presented with its tail.
- R6: In each window cycle, the injected-flit total rises by the number of set bits in `inj_flit_vld`.
- R7: The span readout equals the cycle of the last counted tail minus the cycle of the first header seen in the window. It is 0 while no packet has been counted.
- R8: Each total saturates at 2^CNT_W-1 and never wraps.
- R9: Once `window_done` is 1, no readout value and no flag changes, whatever traffic follows.
- R10: `orphan_err` becomes 1 and stays 1 when a tail arrives before the window ends on a tag that has no outstanding header. This includes a second tail for the same header.
- R11: The readout uses these `rd_sel` codes: 0 = message count, 1 = latency sum, 2 = hop sum, 3 = injected flits, 4 = span. Codes 5 to 7 return 0.
- R12: A header arriving on a tag in the same cycle as that tag's tail does not disturb the older packet. The tail completes the older packet, and the new header arms the tag for a later tail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inj_flit_vld | input | NUM_CORES | One bit per core, set when that core injects a flit this cycle |
| hdr_vld | input | 1 | A header flit leaves its source this cycle |
| hdr_tag | input | TAG_W | Tag of that packet |
| tail_vld | input | 1 | A tail flit is accepted at its destination this cycle |
| tail_tag | input | TAG_W | Tag of the packet whose tail is accepted |
| tail_hops | input | HOP_W | Hops travelled by that packet |
| rd_sel | input | 3 | Readout selection code |
| rd_data | output | CNT_W | Selected total |
| meas_active | output | 1 | Measurement window is open |
| window_done | output | 1 | Window has ended and totals are frozen |
| orphan_err | output | 1 | Sticky flag for a tail without an outstanding header |

## Verification
Several rules are checked on every cycle by assertions:
- the phase flags stay mutually exclusive, and done never drops;
- totals only grow, and each holds whenever its enable is low;
- the message count moves only after a tail;
- the injected-flit total stays still outside the window;
- the orphan flag is sticky.

Other rules depend on arithmetic across many packets, so only the bench's scenarios can show them:
- the exact latency and hop sums;
- exclusion of packets that straddle the warm-up boundary;
- same-cycle tag reuse;
- the moment of saturation;
- the span value.

The bench checks these by comparing the readout with totals it builds from its own record of the traffic it drove.

// File: rtl/noc_mon_pkg.sv
package noc_mon_pkg;
  typedef enum logic [1:0] {
    PH_WARM = 2'd0,
    PH_MEAS = 2'd1,
    PH_DONE = 2'd2
  } phase_e;

  localparam int NACC    = 4;
  localparam int ACC_MSG = 0;
  localparam int ACC_LAT = 1;
  localparam int ACC_HOP = 2;
  localparam int ACC_INJ = 3;

  localparam logic [2:0] SEL_SPAN = 3'd4;
endpackage

// File: rtl/noc_mon_phase.sv
module noc_mon_phase
  import noc_mon_pkg::*;
#(
  parameter int unsigned WARMUP_CYC = 1500,
  parameter int unsigned WINDOW_CYC = 18500,
  parameter int unsigned TS_W       = 15
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [TS_W-1:0] cyc,
  output phase_e          phase,
  output logic            meas,
  output logic            done
);
  localparam int unsigned    END_CYC  = WARMUP_CYC + WINDOW_CYC;
  localparam logic [TS_W-1:0] WARM_END = TS_W'(WARMUP_CYC);
  localparam logic [TS_W-1:0] WIN_END  = TS_W'(END_CYC);

  // Cycle counter stops at the end of the window so the phase stays DONE.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cyc <= '0;
    else if (cyc != WIN_END) cyc <= cyc + 1'b1;
  end

  always_comb begin
    if (cyc < WARM_END)     phase = PH_WARM;
    else if (cyc < WIN_END) phase = PH_MEAS;
    else                    phase = PH_DONE;
  end

  assign meas = (phase == PH_MEAS);
  assign done = (phase == PH_DONE);

  a_r2_phase_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({meas, done}));
  a_r2_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);
  a_r2_window_opens_on_time: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(meas) |-> (cyc == WARM_END));
endmodule

// File: rtl/noc_mon_tag_table.sv
module noc_mon_tag_table #(
  parameter int unsigned TAG_W = 6,
  parameter int unsigned TS_W  = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hdr_vld,
  input  logic [TAG_W-1:0] hdr_tag,
  input  logic             tail_vld,
  input  logic [TAG_W-1:0] tail_tag,
  input  logic [TS_W-1:0]  cyc,
  input  logic             meas,
  input  logic             done,
  output logic             tail_counted,
  output logic [TS_W-1:0]  tail_lat,
  output logic             orphan
);
  localparam int unsigned NTAGS = 1 << TAG_W;

  logic [TS_W-1:0]  ts_q [NTAGS];
  logic [NTAGS-1:0] busy_q;
  logic [NTAGS-1:0] win_q;
  logic             tail_hit;

  assign tail_hit     = tail_vld && busy_q[tail_tag];
  assign tail_counted = tail_hit && win_q[tail_tag] && meas;
  assign tail_lat     = cyc - ts_q[tail_tag];
  assign orphan       = tail_vld && !busy_q[tail_tag] && !done;

  always_ff @(posedge clk) begin
    if (hdr_vld) ts_q[hdr_tag] <= cyc;
  end

  // The tail retires the old entry first; a header on the same tag re-arms it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= '0;
      win_q  <= '0;
    end else begin
      if (tail_hit) busy_q[tail_tag] <= 1'b0;
      if (hdr_vld) begin
        busy_q[hdr_tag] <= 1'b1;
        win_q[hdr_tag]  <= meas;
      end
    end
  end

  a_r12_header_arms_tag: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_vld |=> busy_q[$past(hdr_tag)]);
  a_r3_latency_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    tail_counted |-> (tail_lat != '0));
endmodule

// File: rtl/noc_mon_sat_acc.sv
module noc_mon_sat_acc #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] inc,
  output logic [CNT_W-1:0] q
);
  function automatic logic [CNT_W-1:0] sat_add(input logic [CNT_W-1:0] a,
                                                input logic [CNT_W-1:0] b);
    logic [CNT_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[CNT_W] ? '1 : s[CNT_W-1:0];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= sat_add(q, inc);
  end

  a_r8_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (q >= $past(q)));
  a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(q));
endmodule

// File: rtl/noc_perf_monitor.sv
module noc_perf_monitor
  import noc_mon_pkg::*;
#(
  parameter int unsigned NUM_CORES  = 64,
  parameter int unsigned TAG_W      = 6,
  parameter int unsigned HOP_W      = 4,
  parameter int unsigned CNT_W      = 32,
  parameter int unsigned WARMUP_CYC = 1500,
  parameter int unsigned WINDOW_CYC = 18500
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_CORES-1:0] inj_flit_vld,
  input  logic                 hdr_vld,
  input  logic [TAG_W-1:0]     hdr_tag,
  input  logic                 tail_vld,
  input  logic [TAG_W-1:0]     tail_tag,
  input  logic [HOP_W-1:0]     tail_hops,
  input  logic [2:0]           rd_sel,
  output logic [CNT_W-1:0]     rd_data,
  output logic                 meas_active,
  output logic                 window_done,
  output logic                 orphan_err
);
  localparam int unsigned TS_W = $clog2(WARMUP_CYC + WINDOW_CYC + 1);

  function automatic logic [CNT_W-1:0] count_ones(input logic [NUM_CORES-1:0] v);
    logic [CNT_W-1:0] n;
    n = '0;
    for (int i = 0; i < int'(NUM_CORES); i++) n = n + CNT_W'(v[i]);
    return n;
  endfunction

  logic [TS_W-1:0]  cyc;
  phase_e           phase;
  logic             meas, done;
  logic             tail_counted, orphan;
  logic [TS_W-1:0]  tail_lat;
  logic             acc_en  [NACC];
  logic [CNT_W-1:0] acc_inc [NACC];
  logic [CNT_W-1:0] acc_q   [NACC];
  logic [TS_W-1:0]  first_q, last_q, span;
  logic             seen_q, have_q, err_q;

  noc_mon_phase #(.WARMUP_CYC(WARMUP_CYC), .WINDOW_CYC(WINDOW_CYC), .TS_W(TS_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .cyc(cyc), .phase(phase), .meas(meas), .done(done));

  noc_mon_tag_table #(.TAG_W(TAG_W), .TS_W(TS_W)) u_tags (
    .clk(clk), .rst_n(rst_n), .hdr_vld(hdr_vld), .hdr_tag(hdr_tag),
    .tail_vld(tail_vld), .tail_tag(tail_tag), .cyc(cyc), .meas(meas), .done(done),
    .tail_counted(tail_counted), .tail_lat(tail_lat), .orphan(orphan));

  always_comb begin
    acc_en[ACC_MSG]  = tail_counted;
    acc_inc[ACC_MSG] = CNT_W'(1);
    acc_en[ACC_LAT]  = tail_counted;
    acc_inc[ACC_LAT] = CNT_W'(tail_lat);
    acc_en[ACC_HOP]  = tail_counted;
    acc_inc[ACC_HOP] = CNT_W'(tail_hops);
    acc_en[ACC_INJ]  = meas;
    acc_inc[ACC_INJ] = count_ones(inj_flit_vld);
  end

  for (genvar gi = 0; gi < NACC; gi++) begin : g_acc
    noc_mon_sat_acc #(.CNT_W(CNT_W)) u_acc (
      .clk(clk), .rst_n(rst_n), .en(acc_en[gi]), .inc(acc_inc[gi]), .q(acc_q[gi]));
  end

  // Span bookkeeping: first header of the window and last counted tail.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q <= '0;
      last_q  <= '0;
      seen_q  <= 1'b0;
      have_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      if (hdr_vld && meas && !seen_q) begin
        first_q <= cyc;
        seen_q  <= 1'b1;
      end
      if (tail_counted) begin
        last_q <= cyc;
        have_q <= 1'b1;
      end
      if (orphan) err_q <= 1'b1;
    end
  end

  assign span = have_q ? (last_q - first_q) : '0;

  always_comb begin
    case (rd_sel)
      3'd0:     rd_data = acc_q[ACC_MSG];
      3'd1:     rd_data = acc_q[ACC_LAT];
      3'd2:     rd_data = acc_q[ACC_HOP];
      3'd3:     rd_data = acc_q[ACC_INJ];
      SEL_SPAN: rd_data = CNT_W'(span);
      default:  rd_data = '0;
    endcase
  end

  assign meas_active = meas;
  assign window_done = done;
  assign orphan_err  = err_q;

  a_r3_msg_needs_tail: assert property (@(posedge clk) disable iff (!rst_n)
    !tail_vld |=> $stable(acc_q[ACC_MSG]));
  a_r4_inj_quiet_outside: assert property (@(posedge clk) disable iff (!rst_n)
    !meas_active |=> $stable(acc_q[ACC_INJ]));
  a_r9_frozen_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    window_done |=> ($stable(acc_q[ACC_LAT]) && $stable(span) && $stable(orphan_err)));
  a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    orphan_err |=> orphan_err);
  a_r10_orphan_sets_err: assert property (@(posedge clk) disable iff (!rst_n)
    orphan |=> orphan_err);
  a_r7_span_order: assert property (@(posedge clk) disable iff (!rst_n)
    have_q |-> (seen_q && (last_q >= first_q)));
endmodule

// File: tb/noc_perf_monitor_tb.sv
module noc_perf_monitor_tb;
  localparam int NC    = 4;
  localparam int TAG_W = 4;
  localparam int HOP_W = 3;
  localparam int CNT_W = 11;
  localparam int W     = 40;
  localparam int N     = 400;
  localparam int NT    = 1 << TAG_W;
  localparam longint MAXV = (longint'(1) << CNT_W) - 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [NC-1:0]    inj_flit_vld = '0;
  logic             hdr_vld = 1'b0;
  logic [TAG_W-1:0] hdr_tag = '0;
  logic             tail_vld = 1'b0;
  logic [TAG_W-1:0] tail_tag = '0;
  logic [HOP_W-1:0] tail_hops = '0;
  logic [2:0]       rd_sel = '0;
  logic [CNT_W-1:0] rd_data;
  logic             meas_active, window_done, orphan_err;

  noc_perf_monitor #(.NUM_CORES(NC), .TAG_W(TAG_W), .HOP_W(HOP_W), .CNT_W(CNT_W),
                     .WARMUP_CYC(W), .WINDOW_CYC(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .inj_flit_vld(inj_flit_vld), .hdr_vld(hdr_vld),
    .hdr_tag(hdr_tag), .tail_vld(tail_vld), .tail_tag(tail_tag), .tail_hops(tail_hops),
    .rd_sel(rd_sel), .rd_data(rd_data), .meas_active(meas_active),
    .window_done(window_done), .orphan_err(orphan_err));

  always #10 clk = ~clk;

  int     n_chk = 0, n_bad = 0;
  bit     finished = 0;
  // Bench-side record of the traffic.
  bit     m_busy [NT];
  bit     m_win  [NT];
  longint m_ts   [NT];
  longint raw_msg = 0, raw_lat = 0, raw_hop = 0, raw_inj = 0;
  longint first_c = 0, last_c = 0;
  bit     seen = 0, have = 0, m_err = 0;

  function automatic longint sat(input longint v);
    return (v > MAXV) ? MAXV : v;
  endfunction

  function automatic longint expect_sel(input int s);
    case (s)
      0: return sat(raw_msg);
      1: return sat(raw_lat);
      2: return sat(raw_hop);
      3: return sat(raw_inj);
      4: return have ? (last_c - first_c) : 0;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic read_sel(input int s, output longint v);
    rd_sel = 3'(s);
    #1;
    v = longint'(rd_data);
  endtask

  task automatic check_totals(input string tagline);
    string names [5] = '{"R3 msg", "R3 lat", "R5 hop", "R6 inj", "R7 span"};
    longint v;
    for (int s = 0; s < 5; s++) begin
      read_sel(s, v);
      chk({names[s], " ", tagline}, v, expect_sel(s));
    end
  endtask

  // Apply one cycle of stimulus to the bench record, same rules as the requirements.
  task automatic model_cycle(input int k, input bit hv, input int ht, input bit tv,
                             input int tt, input int th, input logic [NC-1:0] inj);
    bit meas, done;
    meas = (k >= W) && (k < W + N);
    done = (k >= W + N);
    if (tv) begin
      if (m_busy[tt]) begin
        if (m_win[tt] && meas) begin
          raw_msg++;
          raw_lat += longint'(k) - m_ts[tt];
          raw_hop += th;
          last_c = k;
          have = 1;
        end
        m_busy[tt] = 0;
      end else if (!done) m_err = 1;
    end
    if (hv) begin
      m_busy[ht] = 1;
      m_ts[ht]   = k;
      m_win[ht]  = meas;
      if (meas && !seen) begin
        first_c = k;
        seen = 1;
      end
    end
    if (meas) raw_inj += $countones(inj);
  endtask

  initial begin
    #(20 * 20000);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    longint v;
    void'($urandom(32'd7321));
    for (int t = 0; t < NT; t++) begin
      m_busy[t] = 0; m_win[t] = 0; m_ts[t] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    for (int s = 0; s < 8; s++) begin
      read_sel(s, v);
      chk("R1 readout in reset", v, 0);
    end
    chk("R1 flags in reset", {meas_active, window_done, orphan_err}, 0);
    rst_n = 1'b1;

    for (int k = 0; k <= W + N + 40; k++) begin
      bit hv, tv;
      int ht, tt, th;
      logic [NC-1:0] inj;
      // Checks see registers that hold cycles 0..k-1.
      if (k == W - 1) chk("R2 meas before window", meas_active, 0);
      if (k == W) begin
        chk("R2 meas at window start", meas_active, 1);
        read_sel(3, v);
        chk("R4 no warm-up injection counted", v, 0);
      end
      if (k == W + 10) begin
        check_totals("after directed");
        read_sel(0, v);
        chk("R4 straddling packet excluded", v, expect_sel(0));
        chk("R12 same-cycle reuse no orphan", orphan_err, 0);
      end
      if (k == W + 150) check_totals("mid window");
      if (k == W + N - 6) chk("R10 flag clear before orphan", orphan_err, 0);
      if (k == W + N - 1) chk("R2 window last cycle", {meas_active, window_done}, 2'b10);
      if (k == W + N) begin
        chk("R2 done asserted", {meas_active, window_done}, 2'b01);
        check_totals("window end");
        read_sel(1, v);
        chk("R8 latency sum saturation", v, sat(raw_lat));
        chk("R10 orphan flagged", orphan_err, m_err);
        for (int s = 5; s < 8; s++) begin
          read_sel(s, v);
          chk("R11 unused select reads zero", v, 0);
        end
      end
      if (k == W + N + 40) begin
        check_totals("R9 frozen");
        chk("R9 flag frozen", orphan_err, 1);
      end

      hv = 0; tv = 0; ht = 0; tt = 0; th = 0;
      if (k == W - 2) begin hv = 1; ht = 1; end
      if (k == W + 2) begin hv = 1; ht = 0; end
      if (k == W + 3) begin tv = 1; tt = 1; th = 5; end
      if (k == W + 5) begin tv = 1; tt = 0; th = 2; hv = 1; ht = 0; end
      if (k == W + 9) begin tv = 1; tt = 0; th = 6; end
      if (k == W + N - 5) begin tv = 1; tt = 1; th = 1; end
      if (!tv && ($urandom % 2 == 0)) begin
        int off = int'($urandom % 14);
        for (int i = 0; i < 14; i++) begin
          int t = 2 + (off + i) % 14;
          if (!tv && m_busy[t]) begin tv = 1; tt = t; th = int'($urandom % 8); end
        end
      end
      if (!hv && ($urandom % 3 != 0)) begin
        int off = int'($urandom % 14);
        for (int i = 0; i < 14; i++) begin
          int t = 2 + (off + i) % 14;
          if (!hv && !m_busy[t] && !(tv && tt == t)) begin hv = 1; ht = t; end
        end
      end
      inj = NC'($urandom);
      hdr_vld = hv; hdr_tag = TAG_W'(ht);
      tail_vld = tv; tail_tag = TAG_W'(tt); tail_hops = HOP_W'(th);
      inj_flit_vld = inj;
      model_cycle(k, hv, ht, tv, tt, th, inj);
      @(negedge clk);
    end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule